// File: doc/BRIEF.md
# Activity-Driven Scan Clock Controller

This block paces the shifting of one scan chain in a self-test setup where a vector is shifted in, then captured. The chain is filled one bit at a time from a pseudo-random serial source. While it shifts, the controller keeps a running count of the neighbouring bit pairs in the chain that hold different values. It uses that count to choose how many reference-clock cycles to wait before the next shift. When the chain is quiet it shifts every cycle. When it is busy it spaces the shifts further apart. Shift activity per unit time therefore never rises above the rate that a uniform clock sized for the worst case would give.

The chain spans every scanned element: primary inputs, internal flip-flops and primary outputs. A vector is `CHAIN_LEN` shifts long. A pulse on `start` launches one vector. `vec_done` marks the last shift of that vector, and the block then waits for the next `start`. The chain contents and the activity count carry over from one vector to the next. The number of rates `NUM_RATES` is a power of two.

Top module: `scan_rate_ctrl`

## Requirements
- R1: After reset the chain holds all zeros, `trans_cnt` is 0, `rate_idx` is 0, and `shift_en` and `vec_done` are low.
- R2: While idle, `shift_en` stays low and `sdi` has no effect: `trans_cnt` and `rate_idx` do not change.
- R3: Bit 0 of the chain is the entry end. On a shift, the value sampled on `sdi` enters bit 0 and every bit moves up one position. `trans_cnt` then equals the number of positions i in 0..CHAIN_LEN-2 where bit i differs from bit i+1.
- R4: `rate_idx` equals floor(`trans_cnt` * NUM_RATES / CHAIN_LEN), computed from the count after the most recent shift.
- R5: A shift happens at the clock edge that ends the (`rate_idx`+1)-th running cycle after the previous shift or after the start cycle. `shift_en` is high for exactly the one cycle after each shift edge.
- R6: The CHAIN_LEN-th shift of a vector raises `vec_done` for one cycle, together with `shift_en`. The block then returns to idle.
- R7: The chain and `trans_cnt` are kept from the end of one vector into the next.
- R8: `start` asserted while a vector is shifting has no effect on the pacing.
- R9: `trans_cnt` * NUM_RATES < (`rate_idx`+1) * CHAIN_LEN at all times. This is the per-cycle activity budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one vector when idle |
| sdi | input | 1 | Serial test data from the pattern source |
| shift_en | output | 1 | One-cycle strobe following each shift |
| rate_idx | output | $clog2(NUM_RATES) | Selected rate bin; period is rate_idx+1 cycles |
| trans_cnt | output | $clog2(CHAIN_LEN+1) | Live count of differing neighbour pairs |
| vec_done | output | 1 | High with the last shift of a vector |

## Verification
The hardest case to reach from the ports is the chain at its top activity bin. Reaching it requires nearly every neighbour pair to differ, which means the serial data must alternate in step with the shifts even as the period stretches. A data source that simply toggles on every reference cycle would fall into alignment with a two-cycle period and flatten the chain. The stimulus therefore toggles the serial bit only after each shift, which drives the count up to CHAIN_LEN-1 and the rate to its slowest bin. An all-ones vector that follows then walks the count back down through every bin as the old pattern drains out of the tail.

// File: rtl/scc_pkg.sv
package scc_pkg;

    // Pacing mode of the shift sequencer
    typedef enum logic {
        PACE_IDLE = 1'b0,
        PACE_RUN  = 1'b1
    } pace_mode_t;

endpackage

// File: rtl/scc_chain.sv
// Scan chain storage: bit 0 takes the new serial bit, the top bit leaves.
module scc_chain #(
    parameter int CHAIN_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_fire,
    input  logic sdi,
    output logic head_bit,
    output logic tail_diff
);

    typedef struct packed {
        logic [CHAIN_LEN-1:0] bits;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_fire) begin
            st_d.bits = {st_q.bits[CHAIN_LEN-2:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_bit  = st_q.bits[0];
    // pair that disappears when the top bit is shifted out
    assign tail_diff = st_q.bits[CHAIN_LEN-1] ^ st_q.bits[CHAIN_LEN-2];

endmodule

// File: rtl/scc_activity.sv
// Incremental neighbour-difference counter and rate-bin selector.
module scc_activity #(
    parameter int CHAIN_LEN = 16,
    parameter int NUM_RATES = 4,
    localparam int CNT_W    = $clog2(CHAIN_LEN + 1),
    localparam int RATE_W   = $clog2(NUM_RATES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_fire,
    input  logic              sdi,
    input  logic              head_bit,
    input  logic              tail_diff,
    output logic [CNT_W-1:0]  cnt,
    output logic [RATE_W-1:0] rate
);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [RATE_W-1:0] rate;
    } act_st_t;

    act_st_t            st_d, st_q;
    logic [CNT_W-1:0]   nxt_cnt;
    logic [NUM_RATES-2:0] at_or_above;

    // count after this cycle: a new pair appears at the entry, one leaves at the top
    always_comb begin
        nxt_cnt = st_q.cnt;
        if (shift_fire) begin
            nxt_cnt = st_q.cnt + CNT_W'(sdi ^ head_bit) - CNT_W'(tail_diff);
        end
    end

    // one threshold comparator per bin boundary
    for (genvar g = 1; g < NUM_RATES; g++) begin : g_edge
        assign at_or_above[g-1] = (int'(nxt_cnt) * NUM_RATES) >= (g * CHAIN_LEN);
    end

    always_comb begin
        logic [RATE_W-1:0] sum;
        sum = '0;
        for (int i = 0; i < NUM_RATES - 1; i++) begin
            sum = sum + RATE_W'(at_or_above[i]);
        end
        st_d      = st_q;
        st_d.cnt  = nxt_cnt;
        st_d.rate = sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign rate = st_q.rate;

endmodule

// File: rtl/scc_pacer.sv
// Period counter and vector sequencer producing the shift strobe.
module scc_pacer
    import scc_pkg::*;
#(
    parameter int CHAIN_LEN = 16,
    parameter int NUM_RATES = 4,
    localparam int RATE_W   = $clog2(NUM_RATES),
    localparam int BIT_W    = $clog2(CHAIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] rate,
    output logic              shift_fire,
    output logic              shift_strobe,
    output logic              done_strobe
);

    typedef struct packed {
        pace_mode_t        mode;
        logic [RATE_W-1:0] pcnt;
        logic [BIT_W-1:0]  shifts;
        logic              strobe;
        logic              done;
    } pace_st_t;

    pace_st_t st_d, st_q;

    // the period ends when the wait count reaches the selected bin
    assign shift_fire = (st_q.mode == PACE_RUN) && (st_q.pcnt == rate);

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        st_d.done   = 1'b0;
        unique case (st_q.mode)
            PACE_IDLE: begin
                if (start) begin
                    st_d.mode = PACE_RUN;
                    st_d.pcnt = '0;
                end
            end
            PACE_RUN: begin
                if (shift_fire) begin
                    st_d.pcnt   = '0;
                    st_d.strobe = 1'b1;
                    if (st_q.shifts == BIT_W'(CHAIN_LEN - 1)) begin
                        st_d.shifts = '0;
                        st_d.done   = 1'b1;
                        st_d.mode   = PACE_IDLE;
                    end else begin
                        st_d.shifts = st_q.shifts + 1'b1;
                    end
                end else begin
                    st_d.pcnt = st_q.pcnt + 1'b1;
                end
            end
            default: st_d.mode = PACE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: PACE_IDLE, pcnt: '0, shifts: '0, strobe: 1'b0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_strobe = st_q.strobe;
    assign done_strobe  = st_q.done;

endmodule

// File: rtl/scan_rate_ctrl.sv
// Top: scan shift pacing from live chain activity.
// NUM_RATES must be a power of two and at least 2; CHAIN_LEN at least 2.
module scan_rate_ctrl #(
    parameter int CHAIN_LEN = 16,
    parameter int NUM_RATES = 4,
    localparam int CNT_W    = $clog2(CHAIN_LEN + 1),
    localparam int RATE_W   = $clog2(NUM_RATES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sdi,
    output logic              shift_en,
    output logic [RATE_W-1:0] rate_idx,
    output logic [CNT_W-1:0]  trans_cnt,
    output logic              vec_done
);

    logic shift_fire;
    logic head_bit;
    logic tail_diff;

    scc_chain #(
        .CHAIN_LEN (CHAIN_LEN)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_fire (shift_fire),
        .sdi        (sdi),
        .head_bit   (head_bit),
        .tail_diff  (tail_diff)
    );

    scc_activity #(
        .CHAIN_LEN (CHAIN_LEN),
        .NUM_RATES (NUM_RATES)
    ) u_activity (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_fire (shift_fire),
        .sdi        (sdi),
        .head_bit   (head_bit),
        .tail_diff  (tail_diff),
        .cnt        (trans_cnt),
        .rate       (rate_idx)
    );

    scc_pacer #(
        .CHAIN_LEN (CHAIN_LEN),
        .NUM_RATES (NUM_RATES)
    ) u_pacer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .rate         (rate_idx),
        .shift_fire   (shift_fire),
        .shift_strobe (shift_en),
        .done_strobe  (vec_done)
    );

endmodule

// File: rtl/scan_rate_ctrl_chk.sv
module scan_rate_ctrl_chk #(
    parameter int CHAIN_LEN = 16,
    parameter int NUM_RATES = 4,
    localparam int CNT_W    = $clog2(CHAIN_LEN + 1),
    localparam int RATE_W   = $clog2(NUM_RATES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_en,
    input logic [RATE_W-1:0] rate_idx,
    input logic [CNT_W-1:0]  trans_cnt,
    input logic              vec_done
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R4: bin lower edge
    a_r4_bin_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(trans_cnt) * NUM_RATES) >= (int'(rate_idx) * CHAIN_LEN));

    // R9: activity budget per reference cycle
    a_r9_budget: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(trans_cnt) * NUM_RATES) < ((int'(rate_idx) + 1) * CHAIN_LEN));

    // R3: count only moves on a shift
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !shift_en) |-> (trans_cnt == $past(trans_cnt)));

    // R3: one shift changes the count by at most one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && shift_en) |->
            ((int'(trans_cnt) <= int'($past(trans_cnt)) + 1) &&
             (int'(trans_cnt) + 1 >= int'($past(trans_cnt)))));

    // R6: end of vector coincides with a shift
    a_r6_done_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        vec_done |-> shift_en);

endmodule

bind scan_rate_ctrl scan_rate_ctrl_chk #(
    .CHAIN_LEN (CHAIN_LEN),
    .NUM_RATES (NUM_RATES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .rate_idx  (rate_idx),
    .trans_cnt (trans_cnt),
    .vec_done  (vec_done)
);

// File: tb/scan_rate_ctrl_bench.sv
`timescale 1ns/1ps
module scan_rate_ctrl_bench;

    localparam int N  = 16;
    localparam int F  = 4;
    localparam int CW = $clog2(N + 1);
    localparam int RW = $clog2(F);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          sdi = 1'b0;
    logic          shift_en;
    logic [RW-1:0] rate_idx;
    logic [CW-1:0] trans_cnt;
    logic          vec_done;

    always #2.5 clk = ~clk;

    scan_rate_ctrl #(.CHAIN_LEN(N), .NUM_RATES(F)) u_scan_rate_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .sdi(sdi),
        .shift_en(shift_en), .rate_idx(rate_idx),
        .trans_cnt(trans_cnt), .vec_done(vec_done)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // behavioural model
    bit q[$];
    bit m_run = 0;
    int m_wait = 0, m_rate = 0, m_cnt = 0, m_bits = 0, m_vec = 0;
    bit m_shift = 0, m_done = 0;
    bit r8_phase = 0;
    bit tog = 0;
    int lfsr = 32'h1ACE;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int recount();
        int c = 0;
        for (int i = 0; i < N - 1; i++) if (q[i] != q[i+1]) c++;
        return c;
    endfunction

    task automatic step(input bit st, input bit d);
        @(negedge clk);
        check(!m_run && !m_shift ? "R2" : (r8_phase ? "R8" : "R5"), int'(shift_en), int'(m_shift));
        check("R4", int'(rate_idx), m_rate);
        check(m_vec > 0 ? "R7" : "R3", int'(trans_cnt), m_cnt);
        check("R6", int'(vec_done), int'(m_done));
        check("R9", int'(int'(trans_cnt) * F < (int'(rate_idx) + 1) * N), 1);
        start = st;
        sdi   = d;
        m_shift = 0;
        m_done  = 0;
        if (!m_run) begin
            if (st) begin m_run = 1; m_wait = 0; end
        end else if (m_wait == m_rate) begin
            q.push_front(d);
            void'(q.pop_back());
            m_cnt   = recount();
            m_rate  = (m_cnt * F) / N;
            m_shift = 1;
            m_wait  = 0;
            m_bits++;
            if (m_bits == N) begin m_bits = 0; m_done = 1; m_run = 0; end
        end else begin
            m_wait++;
        end
    endtask

    function automatic bit next_bit(input int kind);
        case (kind)
            0: return 1'b0;
            1: return tog;
            2: return lfsr[0];
            default: return 1'b1;
        endcase
    endfunction

    task automatic advance_src(input int kind);
        if (kind == 1 && m_shift) tog = ~tog;
        if (kind == 2) lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
    endtask

    // kind: 0 zeros, 1 alternate per shift, 2 pseudo-random, 3 ones
    task automatic run_vector(input int kind, input bit hold_start);
        step(1'b1, next_bit(kind));
        advance_src(kind);
        while (m_run) begin
            step(hold_start, next_bit(kind));
            advance_src(kind);
        end
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        m_vec++;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) q.push_back(1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state seen through the ports
        check("R1", int'(shift_en), 0);
        check("R1", int'(rate_idx), 0);
        check("R1", int'(trans_cnt), 0);
        check("R1", int'(vec_done), 0);
        rst_n = 1'b1;
        // R2: idle with toggling data
        for (int i = 0; i < 6; i++) step(1'b0, i[0]);
        run_vector(0, 1'b0);
        run_vector(1, 1'b0);
        // R2: idle after a busy vector, data ignored
        for (int i = 0; i < 5; i++) step(1'b0, ~i[0]);
        run_vector(3, 1'b0);
        run_vector(2, 1'b0);
        r8_phase = 1;
        run_vector(1, 1'b1);
        r8_phase = 0;
        run_vector(2, 1'b0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule